// File: doc/BRIEF.md
# Match-Driven Watchdog Reset Timer

The block is a bus-mapped watchdog. A 32-bit up-counter advances on each pulse of a counter-clock enable (`tick`). When counting is enabled and the counter equals a programmed match value on an advancing tick, a set of independently enabled actions fires: the counter can be cleared or frozen, an interrupt flag can be latched, a match output pin can be driven, and an internal reset request, an external reset pulse, or both can be raised.

The external reset output is stretched to a programmable number of counter-clock ticks, and the stretch restarts on every new request. Software can raise either reset request at once through self-clearing force bits, with no match involved. A sticky flag records that the watchdog requested a reset. It survives the ordinary block reset and is cleared only by the power-on reset input. Software restarts the counter by writing the clear request and polling the counter until it reads zero.

The bus is single-cycle. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. A read returns data on `bus_rdata` one cycle after the edge that sampled the request.

Top module: `wdt_match_reset`

## Requirements
- R1: Word registers sit at byte offsets 0x00 irq flag, 0x04 control, 0x08 counter, 0x0C match control, 0x10 match value, 0x14 match-output control, 0x18 pulse length (16 bits), and 0x1C reset flag. All reset to zero. Reads return data one cycle after the request. Writes to 0x08 and 0x1C have no effect.
- R2: With control bit 0 set, the counter increments once per cycle in which `tick` is high. It holds while `tick` is low.
- R3: While control bit 1 (clear) is set, the counter is zero from the next cycle on. Writing 0x2 therefore stops and zeroes it, and a poll of 0x08 reads 0.
- R4: Writing 0 to control stops the counter and keeps its value.
- R5: With control bit 2 set, the counter holds while `dbg_halt` is high.
- R6: A match is an advancing tick on which the counter equals the match value. With match-control bit 0 set, a match sets the irq flag (bit 0 of 0x00, driven on `irq`). Writing 1 to that bit clears the flag.
- R7: With match-control bit 2 set, a match freezes the counter at the match value and clears control bit 0.
- R8: With match-control bit 1 set, a match returns the counter to zero.
- R9: Bit 0 of 0x14 is the match output state, driven on `match_out`, and software writes set it directly. Field [5:4] gives its change on a match: 0 keep, 1 low, 2 high, 3 toggle.
- R10: Match-control bit 3 makes a match raise `rst_int` for one cycle. Writing match control with bit 5 set raises it one cycle after the write.
- R11: Match-control bit 4 on a match, or a match-control write with bit 6 set, (re)starts `rst_ext`. It stays high for exactly the pulse-length number of ticks, and a length of 0 gives no pulse. Bits 5 and 6 read back as 0.
- R12: Bit 0 of 0x1C sets when either reset request is raised. `rst` leaves it unchanged, and only `por` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| por | input | 1 | Power-on reset; also clears the reset flag |
| tick | input | 1 | Counter-clock enable |
| dbg_halt | input | 1 | Debug halt indication |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after request |
| irq | output | 1 | Match interrupt flag |
| match_out | output | 1 | Match output state |
| rst_int | output | 1 | Internal reset request |
| rst_ext | output | 1 | Stretched external reset |

## Verification
The bench polls the counter after a clear request. A design that waited for a tick before clearing would read nonzero there. Stop-on-match is checked by reading back exactly the match value with the enable bit dropped, which catches a design that advances one past the match. The external pulse is measured in high cycles for a single request, a restart in mid-pulse, and a zero length, which exposes off-by-one stretching and missing reloads. The reset flag is read after an ordinary reset and again after power-on reset, so a design that tied it to the wrong reset is caught.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 5;

  localparam logic [2:0] IDX_IRQ   = 3'd0;
  localparam logic [2:0] IDX_CTRL  = 3'd1;
  localparam logic [2:0] IDX_CNT   = 3'd2;
  localparam logic [2:0] IDX_MCTRL = 3'd3;
  localparam logic [2:0] IDX_MATCH = 3'd4;
  localparam logic [2:0] IDX_OUTC  = 3'd5;
  localparam logic [2:0] IDX_PLEN  = 3'd6;
  localparam logic [2:0] IDX_FLAG  = 3'd7;

  localparam int C_EN  = 0;
  localparam int C_CLR = 1;
  localparam int C_DBG = 2;

  localparam int MC_IRQ  = 0;
  localparam int MC_ZERO = 1;
  localparam int MC_STOP = 2;
  localparam int MC_INT  = 3;
  localparam int MC_EXT  = 4;
  localparam int MC_FINT = 5;
  localparam int MC_FEXT = 6;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } match_act_e;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             dbg_halt,
  input  logic             en,
  input  logic             clr,
  input  logic             dbg_freeze,
  input  logic             zero_on_hit,
  input  logic             stop_on_hit,
  input  logic [CNT_W-1:0] match_val,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic adv;

  assign adv = en & tick & ~(dbg_freeze & dbg_halt);
  assign hit = adv & ~clr & (cnt == match_val);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (adv) begin
      if (hit && stop_on_hit) cnt <= cnt;
      else if (hit && zero_on_hit) cnt <= '0;
      else cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PULSE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               req,
  input  logic [PULSE_W-1:0] len,
  output logic               active
);
  logic [PULSE_W-1:0] rem_q, rem_d;

  always_comb begin
    rem_d = rem_q;
    if (req) rem_d = len;
    else if (tick && rem_q != '0) rem_d = rem_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      active <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      active <= (rem_d != '0);
    end
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PULSE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               por,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic [CNT_W-1:0]   cnt,
  input  logic               hit,
  output logic               ctrl_en,
  output logic               ctrl_clr,
  output logic               ctrl_dbg,
  output logic               m_zero,
  output logic               m_stop,
  output logic [CNT_W-1:0]   match_val,
  output logic [PULSE_W-1:0] pulse_len,
  output logic               int_req,
  output logic               ext_req,
  output logic               irq,
  output logic               match_out,
  output logic               rst_flag
);
  logic [2:0]  idx;
  logic        wr;
  logic [4:0]  mctrl;
  match_act_e  act;
  logic        unused_addr_bits;

  assign idx    = bus_addr[ADDR_W-1:2];
  assign wr     = bus_sel & bus_wr;
  assign m_zero = mctrl[MC_ZERO];
  assign m_stop = mctrl[MC_STOP];
  assign unused_addr_bits = ^bus_addr[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en   <= 1'b0;
      ctrl_clr  <= 1'b0;
      ctrl_dbg  <= 1'b0;
      mctrl     <= '0;
      match_val <= '0;
      pulse_len <= '0;
      act       <= ACT_KEEP;
      match_out <= 1'b0;
      irq       <= 1'b0;
      int_req   <= 1'b0;
      ext_req   <= 1'b0;
    end else begin
      if (wr && idx == IDX_CTRL) begin
        ctrl_en  <= bus_wdata[C_EN];
        ctrl_clr <= bus_wdata[C_CLR];
        ctrl_dbg <= bus_wdata[C_DBG];
      end
      if (hit && mctrl[MC_STOP]) ctrl_en <= 1'b0;
      if (wr && idx == IDX_MCTRL) mctrl <= bus_wdata[4:0];
      if (wr && idx == IDX_MATCH) match_val <= bus_wdata[CNT_W-1:0];
      if (wr && idx == IDX_PLEN) pulse_len <= bus_wdata[PULSE_W-1:0];
      if (wr && idx == IDX_OUTC) begin
        act       <= match_act_e'(bus_wdata[5:4]);
        match_out <= bus_wdata[0];
      end else if (hit) begin
        case (act)
          ACT_LOW:    match_out <= 1'b0;
          ACT_HIGH:   match_out <= 1'b1;
          ACT_TOGGLE: match_out <= ~match_out;
          default:    match_out <= match_out;
        endcase
      end
      if (hit && mctrl[MC_IRQ]) irq <= 1'b1;
      else if (wr && idx == IDX_IRQ && bus_wdata[0]) irq <= 1'b0;
      int_req <= (hit & mctrl[MC_INT]) | (wr && idx == IDX_MCTRL && bus_wdata[MC_FINT]);
      ext_req <= (hit & mctrl[MC_EXT]) | (wr && idx == IDX_MCTRL && bus_wdata[MC_FEXT]);
    end
  end

  always_ff @(posedge clk) begin
    if (por) rst_flag <= 1'b0;
    else if (int_req || ext_req) rst_flag <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_sel && !bus_wr) begin
      bus_rdata <= '0;
      case (idx)
        IDX_IRQ:   bus_rdata[0] <= irq;
        IDX_CTRL:  bus_rdata[2:0] <= {ctrl_dbg, ctrl_clr, ctrl_en};
        IDX_CNT:   bus_rdata[CNT_W-1:0] <= cnt;
        IDX_MCTRL: bus_rdata[4:0] <= mctrl;
        IDX_MATCH: bus_rdata[CNT_W-1:0] <= match_val;
        IDX_OUTC:  bus_rdata[5:0] <= {act, 3'b000, match_out};
        IDX_PLEN:  bus_rdata[PULSE_W-1:0] <= pulse_len;
        default:   bus_rdata[0] <= rst_flag;
      endcase
    end
  end
endmodule

// File: rtl/wdt_match_reset.sv
module wdt_match_reset
  import wdt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PULSE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              tick,
  input  logic              dbg_halt,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq,
  output logic              match_out,
  output logic              rst_int,
  output logic              rst_ext
);
  logic               rst_all;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   match_val;
  logic [PULSE_W-1:0] pulse_len;
  logic               hit;
  logic               ctrl_en, ctrl_clr, ctrl_dbg;
  logic               m_zero, m_stop;
  logic               ext_req;
  logic               rst_flag;

  assign rst_all = rst | por;

  wdt_regs #(.CNT_W(CNT_W), .PULSE_W(PULSE_W)) u_regs (
    .clk(clk), .rst(rst_all), .por(por),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt_q), .hit(hit),
    .ctrl_en(ctrl_en), .ctrl_clr(ctrl_clr), .ctrl_dbg(ctrl_dbg),
    .m_zero(m_zero), .m_stop(m_stop),
    .match_val(match_val), .pulse_len(pulse_len),
    .int_req(rst_int), .ext_req(ext_req),
    .irq(irq), .match_out(match_out), .rst_flag(rst_flag)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst_all), .tick(tick), .dbg_halt(dbg_halt),
    .en(ctrl_en), .clr(ctrl_clr), .dbg_freeze(ctrl_dbg),
    .zero_on_hit(m_zero), .stop_on_hit(m_stop),
    .match_val(match_val), .cnt(cnt_q), .hit(hit)
  );

  wdt_pulse #(.PULSE_W(PULSE_W)) u_pulse (
    .clk(clk), .rst(rst_all), .tick(tick),
    .req(ext_req), .len(pulse_len), .active(rst_ext)
  );
endmodule

// File: rtl/wdt_match_reset_chk.sv
module wdt_match_reset_chk #(
  parameter int CNT_W   = 32,
  parameter int PULSE_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               por,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [4:0]         bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [CNT_W-1:0]   cnt_q,
  input logic               ctrl_en,
  input logic               ctrl_clr,
  input logic               hit,
  input logic               m_stop,
  input logic [PULSE_W-1:0] pulse_len,
  input logic               irq,
  input logic               rst_int,
  input logic               rst_ext,
  input logic               rst_flag
);
  logic wr_mctrl, wr_irq;
  assign wr_mctrl = bus_sel && bus_wr && bus_addr[4:2] == 3'd3;
  assign wr_irq   = bus_sel && bus_wr && bus_addr[4:2] == 3'd0;

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst || por)
    ctrl_clr |=> cnt_q == '0);                                          // R3
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst || por)
    (!ctrl_en && !ctrl_clr) |=> $stable(cnt_q));                        // R4
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst || por)
    (wr_irq && bus_wdata[0] && !hit) |=> !irq);                         // R6
  AST_STOP_ON_HIT: assert property (@(posedge clk) disable iff (rst || por)
    (hit && m_stop) |=> (!ctrl_en && $stable(cnt_q)));                  // R7
  AST_FORCE_INT: assert property (@(posedge clk) disable iff (rst || por)
    (wr_mctrl && bus_wdata[5]) |=> rst_int);                            // R10
  AST_FORCE_EXT: assert property (@(posedge clk) disable iff (rst || por)
    (wr_mctrl && bus_wdata[6] && bus_wdata[31:0] == bus_wdata && pulse_len != '0
     && !(bus_sel && bus_wr && bus_addr[4:2] == 3'd6)) |=> ##1 rst_ext); // R11
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (por)
    rst_flag |=> rst_flag);                                             // R12
endmodule

bind wdt_match_reset wdt_match_reset_chk #(.CNT_W(CNT_W), .PULSE_W(PULSE_W)) u_chk (
  .clk(clk), .rst(rst), .por(por), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_q(cnt_q),
  .ctrl_en(ctrl_en), .ctrl_clr(ctrl_clr), .hit(hit), .m_stop(m_stop),
  .pulse_len(pulse_len), .irq(irq), .rst_int(rst_int), .rst_ext(rst_ext),
  .rst_flag(rst_flag)
);

// File: tb/test_wdt_match_reset.sv
`timescale 1ns/1ps
module test_wdt_match_reset;
  logic clk = 1'b0;
  logic rst, por, tick, dbg_halt, bus_sel, bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic irq, match_out, rst_int, rst_ext;
  int checks = 0;
  int errors = 0;
  int ext_hi = 0;
  int int_hi = 0;

  always #2.5 clk = ~clk;

  wdt_match_reset i_wdt_match_reset (
    .clk(clk), .rst(rst), .por(por), .tick(tick), .dbg_halt(dbg_halt),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .match_out(match_out), .rst_int(rst_int), .rst_ext(rst_ext)
  );

  always @(negedge clk) begin
    if (rst_ext) ext_hi <= ext_hi + 1;
    if (rst_int) int_hi <= int_hi + 1;
  end

  // {addr, write data, expected read}
  localparam logic [71:0] VEC [0:7] = '{
    {8'h10, 32'h1234_5678, 32'h1234_5678},
    {8'h18, 32'h0000_ABCD, 32'h0000_ABCD},
    {8'h18, 32'hFFFF_0013, 32'h0000_0013},
    {8'h14, 32'h0000_00F1, 32'h0000_0031},
    {8'h0C, 32'h0000_0012, 32'h0000_0012},
    {8'h0C, 32'hFFFF_FF80, 32'h0000_0000},
    {8'h04, 32'h0000_0004, 32'h0000_0004},
    {8'h08, 32'hDEAD_BEEF, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk);
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int base;
    rst = 1; por = 1; tick = 0; dbg_halt = 0;
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 0; por = 0;

    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd(5'(i * 4), v);
      chk("R1 reset value", v, 32'h0);
    end
    chk("R1 reset outputs", {28'h0, irq, match_out, rst_int, rst_ext}, 32'h0);

    // R1 R9 register map vectors (counter idle, tick low)
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][68:64], VEC[i][63:32]);
      rd(VEC[i][68:64], v);
      chk("R1 readback", v, VEC[i][31:0]);
    end
    chk("R9 direct output set", {31'h0, match_out}, 32'h1);
    wr(5'h14, 32'h0); wr(5'h04, 32'h0);

    // R2 tick gating
    wr(5'h04, 32'h1);
    repeat (5) @(negedge clk);
    rd(5'h08, v); chk("R2 hold without tick", v, 32'h0);
    wr(5'h04, 32'h0);
    wr(5'h04, 32'h1);
    @(negedge clk); tick = 1;
    repeat (7) @(negedge clk);
    tick = 0;
    rd(5'h08, v); chk("R2 count per tick", v, 32'd7);

    // R4 stop keeps value
    tick = 1;
    repeat (10) @(negedge clk);
    wr(5'h04, 32'h0);
    rd(5'h08, v);
    repeat (10) @(negedge clk);
    rd(5'h08, v2);
    chk("R4 stopped value kept", v2, v);
    chk("R4 value nonzero", {31'h0, v != 0}, 32'h1);

    // R3 clear and poll
    wr(5'h04, 32'h2);
    rd(5'h08, v); chk("R3 clear reads zero", v, 32'h0);

    // R5 debug freeze
    wr(5'h04, 32'h0);
    wr(5'h04, 32'h5);
    repeat (6) @(negedge clk);
    dbg_halt = 1;
    rd(5'h08, v);
    repeat (8) @(negedge clk);
    rd(5'h08, v2);
    chk("R5 frozen under halt", v2, v);
    dbg_halt = 0;
    repeat (4) @(negedge clk);
    rd(5'h08, v2);
    chk("R5 resumes after halt", {31'h0, v2 > v}, 32'h1);

    // R6 R7 R9 stop on match with irq and output high
    wr(5'h04, 32'h2);
    wr(5'h04, 32'h0);
    wr(5'h10, 32'd5);
    wr(5'h14, 32'h20);
    wr(5'h0C, 32'h05);
    wr(5'h04, 32'h1);
    repeat (20) @(negedge clk);
    rd(5'h08, v); chk("R7 frozen at match", v, 32'd5);
    rd(5'h04, v); chk("R7 enable dropped", v, 32'h0);
    chk("R6 irq raised", {31'h0, irq}, 32'h1);
    chk("R9 output driven high", {31'h0, match_out}, 32'h1);
    rd(5'h00, v); chk("R6 irq flag reads 1", v, 32'h1);
    wr(5'h00, 32'h1);
    chk("R6 irq cleared", {31'h0, irq}, 32'h0);
    wr(5'h14, 32'h0);
    chk("R9 direct clear", {31'h0, match_out}, 32'h0);

    // R8 R10 clear on match with internal reset
    wr(5'h04, 32'h2); wr(5'h04, 32'h0);
    wr(5'h10, 32'd3);
    wr(5'h0C, 32'h0A);
    base = int_hi;
    wr(5'h04, 32'h1);
    repeat (40) @(negedge clk);
    wr(5'h04, 32'h0);
    rd(5'h08, v); chk("R8 counter wraps at match", {31'h0, v <= 3}, 32'h1);
    chk("R10 pulses on matches", {31'h0, (int_hi - base) >= 8 && (int_hi - base) <= 12}, 32'h1);
    wr(5'h0C, 32'h0);
    rd(5'h1C, v); chk("R12 flag set", v, 32'h1);

    // R10 forced internal request
    base = int_hi;
    wr(5'h0C, 32'h20);
    repeat (3) @(negedge clk);
    chk("R10 forced one cycle", int_hi - base, 32'd1);
    rd(5'h0C, v); chk("R11 force bits read zero", v, 32'h0);

    // R11 external pulse widths
    wr(5'h18, 32'd10);
    base = ext_hi;
    wr(5'h0C, 32'h40);
    repeat (30) @(negedge clk);
    chk("R11 pulse length", ext_hi - base, 32'd10);
    base = ext_hi;
    wr(5'h0C, 32'h40);
    repeat (4) @(negedge clk);
    wr(5'h0C, 32'h40);
    repeat (30) @(negedge clk);
    chk("R11 restart extends", {31'h0, (ext_hi - base) >= 12 && (ext_hi - base) <= 20}, 32'h1);
    wr(5'h18, 32'd0);
    base = ext_hi;
    wr(5'h0C, 32'h40);
    repeat (10) @(negedge clk);
    chk("R11 zero length no pulse", ext_hi - base, 32'd0);

    // R12 sticky across rst, cleared by por
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    rd(5'h1C, v); chk("R12 survives rst", v, 32'h1);
    rd(5'h18, v); chk("R1 rst clears regs", v, 32'h0);
    @(negedge clk); por = 1;
    @(negedge clk); por = 0;
    rd(5'h1C, v); chk("R12 cleared by por", v, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule